// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block sits beside the execute stage of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It owns the general register file and the decode-to-execute operand latch. For each of the two source operands of the instruction in execute, it picks the newest value. That value comes from one of three places, in this order: the result register directly behind execute (the nearer one), the result register one stage further on (the older one, which also drives the register file write port), or the value latched from the register file at decode.

The register file completes its write before its read within a cycle. An instruction three slots behind a producer therefore picks up the result at decode, and no third bypass path is needed. The block also compares the source fields of the instruction in decode against a load sitting in execute. When they depend on each other, it raises a one-cycle stall. The surrounding pipeline uses that stall to hold its program counter and decode register, and the block loads an empty slot into execute. The loaded data then reaches the dependent instruction through the older result register. The ALU, data memory and fetch logic sit outside the block.

Top module: `operand_bypass_unit`

## Requirements
- R1: After reset, `stall` and `ex_valid` are 0 and every register reads as zero.
- R2: When the nearer result register is valid and its nonzero tag equals an execute source number, that operand equals `res0_data` and its select output reads 1.
- R3: When only the older result register is valid with a nonzero matching tag, the operand equals `res1_data` and its select reads 2. When both match, the nearer value wins and the select reads 1.
- R4: With no valid matching tag, the operand is the value captured at decode from the register file and its select reads 0.
- R5: Register 0 always reads zero, and its select reads 0. A result tag of 0 is never matched, and a write aimed at register 0 is discarded.
- R6: A valid older result with a nonzero tag is written into the register file at the clock edge. A decode-stage read of that register in the same cycle returns the new value.
- R7: `stall` is 1 in the same cycle when execute holds a valid load with a nonzero destination and a valid decode instruction has that destination in `id_rs1` or in `id_rs2`.
- R8: At the clock edge after a stall, execute shows an empty slot (`ex_valid` 0, `ex_is_load` 0) and the decode instruction is not captured. The held instruction enters execute at the next edge.
- R9: No stall arises for a producer that is not a load, for a load whose destination is 0, for a load two slots ahead of the reader, or when decode holds no valid instruction.
- R10: After a load-use stall, the dependent instruction in execute gets the loaded value from the older result register (select 2).
- R11: A result register whose valid flag is 0 is neither forwarded nor written into the register file.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_is_load | input | 1 | Decode instruction is a load |
| id_rd | input | AW | Decode destination register |
| id_rs1 | input | AW | Decode first source register |
| id_rs2 | input | AW | Decode second source register |
| res0_valid | input | 1 | Nearer result register holds a result |
| res0_rd | input | AW | Destination tag of nearer result |
| res0_data | input | XLEN | Nearer result value |
| res1_valid | input | 1 | Older result register holds a result (also write enable) |
| res1_rd | input | AW | Destination tag of older result (write address) |
| res1_data | input | XLEN | Older result value (write data) |
| stall | output | 1 | Load-use hold request for fetch and decode |
| ex_valid | output | 1 | Execute slot holds an instruction |
| ex_is_load | output | 1 | Execute instruction is a load |
| ex_rd | output | AW | Execute destination register |
| ex_rs1 | output | AW | Execute first source register |
| ex_rs2 | output | AW | Execute second source register |
| ex_op_a | output | XLEN | Selected first operand |
| ex_op_b | output | XLEN | Selected second operand |
| ex_sel_a | output | 2 | First operand origin: 0 latched, 1 nearer, 2 older |
| ex_sel_b | output | 2 | Second operand origin: 0 latched, 1 nearer, 2 older |

## Verification
A corrupted register file entry stays hidden until an instruction reads that register. Once it does, the bad value shows on `ex_op_a` or `ex_op_b` one cycle after decode, with the select at 0. A wrong execute latch (lost valid, stale destination, missing bubble) changes `stall` for the following decode instruction within the same cycle. It also shows on `ex_valid` and `ex_rd` at the next edge. Wrong forwarding priority shows at once on the operand outputs, and only when both result tags match the same source, so those cases are driven on purpose.

// File: rtl/bypass_pkg.sv
`timescale 1ns/1ps
package bypass_pkg;
    localparam int NUM_SRC = 2;

    typedef enum logic [1:0] {
        SRC_LATCH = 2'd0,
        SRC_NEAR  = 2'd1,
        SRC_OLD   = 2'd2
    } src_sel_e;
endpackage

// File: rtl/wt_regfile.sv
`timescale 1ns/1ps
// Register file with write-before-read: a same-cycle write is seen by reads.
module wt_regfile #(
    parameter int XLEN  = 32,
    parameter int NREG  = 32,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [XLEN-1:0]          wr_data,
    input  logic [NRD-1:0][AW-1:0]   rd_addr,
    output logic [NRD-1:0][XLEN-1:0] rd_data
);
    logic [NREG-1:0][XLEN-1:0] mem_d, mem_q;
    logic                      wr_live;

    assign wr_live = wr_en && (wr_addr != '0);

    always_comb begin
        mem_d = mem_q;
        if (wr_live) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (rd_addr[p] == '0) begin
                rd_data[p] = '0;
            end else if (wr_live && (wr_addr == rd_addr[p])) begin
                rd_data[p] = wr_data;
            end else begin
                rd_data[p] = mem_q[rd_addr[p]];
            end
        end
    end
endmodule

// File: rtl/operand_select.sv
`timescale 1ns/1ps
// Picks the newest value of one source operand, nearer result first.
module operand_select
    import bypass_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input  logic [AW-1:0]   src,
    input  logic [XLEN-1:0] latched,
    input  logic            near_valid,
    input  logic [AW-1:0]   near_rd,
    input  logic [XLEN-1:0] near_data,
    input  logic            old_valid,
    input  logic [AW-1:0]   old_rd,
    input  logic [XLEN-1:0] old_data,
    output logic [XLEN-1:0] op,
    output src_sel_e        sel
);
    logic near_hit, old_hit;

    assign near_hit = near_valid && (near_rd != '0) && (near_rd == src);
    assign old_hit  = old_valid  && (old_rd  != '0) && (old_rd  == src);

    always_comb begin
        if (near_hit) begin
            op  = near_data;
            sel = SRC_NEAR;
        end else if (old_hit) begin
            op  = old_data;
            sel = SRC_OLD;
        end else begin
            op  = latched;
            sel = SRC_LATCH;
        end
    end
endmodule

// File: rtl/load_use_detect.sv
`timescale 1ns/1ps
// Flags a decode instruction that reads the destination of a load in execute.
module load_use_detect #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic                  ex_valid,
    input  logic                  ex_is_load,
    input  logic [AW-1:0]         ex_rd,
    input  logic                  id_valid,
    input  logic [NSRC-1:0][AW-1:0] id_src,
    output logic                  stall
);
    logic [NSRC-1:0] hit;
    logic            load_live;

    assign load_live = ex_valid && ex_is_load && (ex_rd != '0);

    for (genvar s = 0; s < NSRC; s++) begin : g_cmp
        assign hit[s] = (id_src[s] == ex_rd);
    end

    assign stall = load_live && id_valid && (|hit);
endmodule

// File: rtl/operand_bypass_unit.sv
`timescale 1ns/1ps
module operand_bypass_unit
    import bypass_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            id_valid,
    input  logic            id_is_load,
    input  logic [AW-1:0]   id_rd,
    input  logic [AW-1:0]   id_rs1,
    input  logic [AW-1:0]   id_rs2,
    input  logic            res0_valid,
    input  logic [AW-1:0]   res0_rd,
    input  logic [XLEN-1:0] res0_data,
    input  logic            res1_valid,
    input  logic [AW-1:0]   res1_rd,
    input  logic [XLEN-1:0] res1_data,
    output logic            stall,
    output logic            ex_valid,
    output logic            ex_is_load,
    output logic [AW-1:0]   ex_rd,
    output logic [AW-1:0]   ex_rs1,
    output logic [AW-1:0]   ex_rs2,
    output logic [XLEN-1:0] ex_op_a,
    output logic [XLEN-1:0] ex_op_b,
    output logic [1:0]      ex_sel_a,
    output logic [1:0]      ex_sel_b
);
    typedef struct packed {
        logic                          valid;
        logic                          is_load;
        logic [AW-1:0]                 rd;
        logic [NUM_SRC-1:0][AW-1:0]    rs;
        logic [NUM_SRC-1:0][XLEN-1:0]  opnd;
    } ex_slot_t;

    ex_slot_t                      ex_d, ex_q;
    logic [NUM_SRC-1:0][AW-1:0]    id_src;
    logic [NUM_SRC-1:0][XLEN-1:0]  id_rdata;
    logic [NUM_SRC-1:0][XLEN-1:0]  fwd_op;
    src_sel_e                      fwd_sel [NUM_SRC];
    logic                          stall_w;

    assign id_src[0] = id_rs1;
    assign id_src[1] = id_rs2;

    wt_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NUM_SRC)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (res1_valid),
        .wr_addr (res1_rd),
        .wr_data (res1_data),
        .rd_addr (id_src),
        .rd_data (id_rdata)
    );

    load_use_detect #(.AW(AW), .NSRC(NUM_SRC)) u_haz (
        .ex_valid   (ex_q.valid),
        .ex_is_load (ex_q.is_load),
        .ex_rd      (ex_q.rd),
        .id_valid   (id_valid),
        .id_src     (id_src),
        .stall      (stall_w)
    );

    // Next execute slot: a bubble on stall, otherwise the decode instruction.
    always_comb begin
        if (stall_w) begin
            ex_d = '0;
        end else begin
            ex_d.valid   = id_valid;
            ex_d.is_load = id_valid && id_is_load;
            ex_d.rd      = id_valid ? id_rd : '0;
            ex_d.rs      = id_src;
            ex_d.opnd    = id_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_q <= '0;
        end else begin
            ex_q <= ex_d;
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_opsel
        operand_select #(.XLEN(XLEN), .AW(AW)) u_sel (
            .src        (ex_q.rs[g]),
            .latched    (ex_q.opnd[g]),
            .near_valid (res0_valid),
            .near_rd    (res0_rd),
            .near_data  (res0_data),
            .old_valid  (res1_valid),
            .old_rd     (res1_rd),
            .old_data   (res1_data),
            .op         (fwd_op[g]),
            .sel        (fwd_sel[g])
        );
    end

    assign stall      = stall_w;
    assign ex_valid   = ex_q.valid;
    assign ex_is_load = ex_q.is_load;
    assign ex_rd      = ex_q.rd;
    assign ex_rs1     = ex_q.rs[0];
    assign ex_rs2     = ex_q.rs[1];
    assign ex_op_a    = fwd_op[0];
    assign ex_op_b    = fwd_op[1];
    assign ex_sel_a   = fwd_sel[0];
    assign ex_sel_b   = fwd_sel[1];
endmodule

// File: rtl/operand_bypass_checker.sv
`timescale 1ns/1ps
module operand_bypass_checker #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            id_valid,
    input logic            res0_valid,
    input logic [AW-1:0]   res0_rd,
    input logic [XLEN-1:0] res0_data,
    input logic            res1_valid,
    input logic [AW-1:0]   res1_rd,
    input logic [XLEN-1:0] res1_data,
    input logic            stall,
    input logic            ex_valid,
    input logic            ex_is_load,
    input logic [AW-1:0]   ex_rd,
    input logic [AW-1:0]   ex_rs1,
    input logic [AW-1:0]   ex_rs2,
    input logic [XLEN-1:0] ex_op_a,
    input logic [XLEN-1:0] ex_op_b,
    input logic [1:0]      ex_sel_a,
    input logic [1:0]      ex_sel_b
);
    p_near_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res0_valid && res0_rd != '0 && res0_rd == ex_rs1)
        |-> (ex_op_a == res0_data && ex_sel_a == 2'd1));

    p_near_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res0_valid && res0_rd != '0 && res0_rd == ex_rs2)
        |-> (ex_op_b == res0_data && ex_sel_b == 2'd1));

    p_old_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(res0_valid && res0_rd == ex_rs1) && res1_valid && res1_rd != '0 && res1_rd == ex_rs1)
        |-> (ex_op_a == res1_data && ex_sel_a == 2'd2));

    p_zero_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs1 == '0) |-> (ex_op_a == '0 && ex_sel_a == 2'd0));

    p_stall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (ex_valid && ex_is_load && ex_rd != '0 && id_valid));

    p_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!ex_valid && !ex_is_load));

    p_idle_id_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> !stall);

    p_no_tags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!res0_valid && !res1_valid) |-> (ex_sel_a == 2'd0 && ex_sel_b == 2'd0));
endmodule

bind operand_bypass_unit operand_bypass_checker #(.XLEN(XLEN), .NREG(NREG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .id_valid   (id_valid),
    .res0_valid (res0_valid),
    .res0_rd    (res0_rd),
    .res0_data  (res0_data),
    .res1_valid (res1_valid),
    .res1_rd    (res1_rd),
    .res1_data  (res1_data),
    .stall      (stall),
    .ex_valid   (ex_valid),
    .ex_is_load (ex_is_load),
    .ex_rd      (ex_rd),
    .ex_rs1     (ex_rs1),
    .ex_rs2     (ex_rs2),
    .ex_op_a    (ex_op_a),
    .ex_op_b    (ex_op_b),
    .ex_sel_a   (ex_sel_a),
    .ex_sel_b   (ex_sel_b)
);

// File: tb/operand_bypass_unit_tb.sv
`timescale 1ns/100ps
module operand_bypass_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        id_valid, id_is_load;
    logic [4:0]  id_rd, id_rs1, id_rs2;
    logic        res0_valid, res1_valid;
    logic [4:0]  res0_rd, res1_rd;
    logic [31:0] res0_data, res1_data;
    logic        stall, ex_valid, ex_is_load;
    logic [4:0]  ex_rd, ex_rs1, ex_rs2;
    logic [31:0] ex_op_a, ex_op_b;
    logic [1:0]  ex_sel_a, ex_sel_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    operand_bypass_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .id_valid(id_valid), .id_is_load(id_is_load), .id_rd(id_rd),
        .id_rs1(id_rs1), .id_rs2(id_rs2),
        .res0_valid(res0_valid), .res0_rd(res0_rd), .res0_data(res0_data),
        .res1_valid(res1_valid), .res1_rd(res1_rd), .res1_data(res1_data),
        .stall(stall), .ex_valid(ex_valid), .ex_is_load(ex_is_load),
        .ex_rd(ex_rd), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .ex_op_a(ex_op_a), .ex_op_b(ex_op_b),
        .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic launch(input logic ld, input logic [4:0] rd, input logic [4:0] s1, input logic [4:0] s2);
        id_valid = 1'b1; id_is_load = ld; id_rd = rd; id_rs1 = s1; id_rs2 = s2;
    endtask

    task automatic id_idle();
        id_valid = 1'b0; id_is_load = 1'b0;
    endtask

    task automatic res_clear();
        res0_valid = 1'b0; res1_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 stall after reset", {31'd0, stall}, 32'd0);
        chk("R1 ex_valid after reset", {31'd0, ex_valid}, 32'd0);
        @(negedge clk); launch(1'b0, 5'd1, 5'd5, 5'd6);
        @(negedge clk); id_idle(); #0.5;
        chk("R1 r5 reads zero", ex_op_a, 32'd0);
        chk("R1 r6 reads zero", ex_op_b, 32'd0);
    endtask

    task automatic t_write_then_read();
        @(negedge clk);
        res1_valid = 1'b1; res1_rd = 5'd5; res1_data = 32'h1111_0005;
        launch(1'b0, 5'd1, 5'd5, 5'd31);
        @(negedge clk); res_clear(); id_idle(); #0.5;
        chk("R6 same-cycle write seen at decode", ex_op_a, 32'h1111_0005);
        chk("R4 select latched", {30'd0, ex_sel_a}, 32'd0);
    endtask

    task automatic t_forward();
        @(negedge clk);
        res1_valid = 1'b1; res1_rd = 5'd7; res1_data = 32'h0000_000A;
        @(negedge clk); res_clear(); launch(1'b0, 5'd2, 5'd7, 5'd7);
        @(negedge clk); id_idle();
        res0_valid = 1'b1; res0_rd = 5'd7; res0_data = 32'h0000_000B;
        res1_valid = 1'b1; res1_rd = 5'd7; res1_data = 32'h0000_000C;
        #0.3;
        chk("R3 nearer wins when both match", ex_op_a, 32'h0000_000B);
        chk("R3 select nearer", {30'd0, ex_sel_a}, 32'd1);
        chk("R2 second operand from nearer", ex_op_b, 32'h0000_000B);
        res0_rd = 5'd9; #0.3;
        chk("R3 older used", ex_op_a, 32'h0000_000C);
        chk("R3 select older", {30'd0, ex_sel_a}, 32'd2);
        res1_valid = 1'b0; #0.3;
        chk("R4 latched value", ex_op_a, 32'h0000_000A);
        res0_valid = 1'b0; res0_rd = 5'd7; #0.3;
        chk("R11 invalid tags not forwarded", ex_op_a, 32'h0000_000A);
        chk("R11 select latched", {30'd0, ex_sel_b}, 32'd0);
        @(negedge clk); launch(1'b0, 5'd2, 5'd7, 5'd0);
        @(negedge clk); id_idle(); #0.5;
        chk("R11 invalid older result not written", ex_op_a, 32'h0000_000A);
    endtask

    task automatic t_zero();
        @(negedge clk);
        res1_valid = 1'b1; res1_rd = 5'd0; res1_data = 32'hFFFF_FFFF;
        launch(1'b0, 5'd3, 5'd0, 5'd0);
        @(negedge clk); res_clear(); id_idle();
        res0_valid = 1'b1; res0_rd = 5'd0; res0_data = 32'hDEAD_BEEF;
        #0.5;
        chk("R5 register 0 reads zero", ex_op_a, 32'd0);
        chk("R5 tag 0 not matched", {30'd0, ex_sel_a}, 32'd0);
        res_clear();
        @(negedge clk); launch(1'b0, 5'd3, 5'd0, 5'd0);
        @(negedge clk); id_idle(); #0.5;
        chk("R5 write to register 0 dropped", ex_op_b, 32'd0);
    endtask

    task automatic t_load_use();
        @(negedge clk); launch(1'b1, 5'd4, 5'd0, 5'd0);
        @(negedge clk); launch(1'b0, 5'd9, 5'd4, 5'd0); #0.5;
        chk("R7 stall on rs1 match", {31'd0, stall}, 32'd1);
        @(negedge clk);
        res0_valid = 1'b1; res0_rd = 5'd4; res0_data = 32'h0000_0BAD;
        #0.5;
        chk("R8 bubble valid", {31'd0, ex_valid}, 32'd0);
        chk("R8 bubble not a load", {31'd0, ex_is_load}, 32'd0);
        chk("R8 stall lasts one cycle", {31'd0, stall}, 32'd0);
        @(negedge clk);
        res0_valid = 1'b0;
        res1_valid = 1'b1; res1_rd = 5'd4; res1_data = 32'h0000_0044;
        launch(1'b0, 5'd10, 5'd0, 5'd4);
        #0.5;
        chk("R8 held instruction enters execute", {27'd0, ex_rd}, 32'd9);
        chk("R10 loaded value forwarded", ex_op_a, 32'h0000_0044);
        chk("R10 select older", {30'd0, ex_sel_a}, 32'd2);
        @(negedge clk); res_clear(); id_idle(); #0.5;
        chk("R6 third slot reads file", ex_op_b, 32'h0000_0044);
        chk("R6 select latched", {30'd0, ex_sel_b}, 32'd0);
        @(negedge clk); launch(1'b1, 5'd6, 5'd0, 5'd0);
        @(negedge clk); launch(1'b0, 5'd11, 5'd3, 5'd6); #0.5;
        chk("R7 stall on rs2 match", {31'd0, stall}, 32'd1);
        @(negedge clk); id_idle();
        @(negedge clk);
    endtask

    task automatic t_no_stall();
        @(negedge clk); launch(1'b0, 5'd4, 5'd0, 5'd0);
        @(negedge clk); launch(1'b0, 5'd8, 5'd4, 5'd4); #0.5;
        chk("R9 non-load producer", {31'd0, stall}, 32'd0);
        @(negedge clk); launch(1'b1, 5'd0, 5'd0, 5'd0);
        @(negedge clk); launch(1'b0, 5'd8, 5'd0, 5'd0); #0.5;
        chk("R9 load to register 0", {31'd0, stall}, 32'd0);
        @(negedge clk); launch(1'b1, 5'd5, 5'd0, 5'd0);
        @(negedge clk); launch(1'b0, 5'd8, 5'd1, 5'd2); #0.5;
        chk("R9 unrelated follower", {31'd0, stall}, 32'd0);
        @(negedge clk); launch(1'b0, 5'd8, 5'd5, 5'd0); #0.5;
        chk("R9 load two slots ahead", {31'd0, stall}, 32'd0);
        @(negedge clk); launch(1'b1, 5'd5, 5'd0, 5'd0);
        @(negedge clk); id_idle(); id_rs1 = 5'd5; #0.5;
        chk("R9 no valid decode instruction", {31'd0, stall}, 32'd0);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        rst_n = 1'b0;
        id_valid = 1'b0; id_is_load = 1'b0; id_rd = '0; id_rs1 = '0; id_rs2 = '0;
        res0_valid = 1'b0; res0_rd = '0; res0_data = '0;
        res1_valid = 1'b0; res1_rd = '0; res1_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        t_reset();
        t_write_then_read();
        t_forward();
        t_zero();
        t_load_use();
        t_no_stall();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule